// File: doc/BRIEF.md
# Configurable Full-Period LFSR Generator

This block is a pseudo-random state generator built from a linear feedback shift register whose length is chosen at elaboration between 2 and 32 bits. A compiled-in table gives a maximal-length tap set for every length. Three further elaboration options pick the rest of the design. The first is the shift structure: one-to-many, where the MSB is fed into several stages, or many-to-one, where several stages are combined into the LSB. The second is the gate used in the feedback network, XOR or XNOR. The third is an extension that adds the normally forbidden lockup state to the loop, so the register runs through all 2^n values.

In use the register is reset to a safe default or loaded with a seed. It then moves one state per clock while the advance input is high. The full register value is presented every cycle on a parallel output. In the plain (non-extended) modes the lockup value must never be loaded, because the register stays there for good.

Top module: `lfsr_gen`

## Requirements
- R1: Synchronous reset (rst_i high at a rising edge) sets the state to all ones when the gate is XOR and to all zeros when the gate is XNOR. This holds with and without the extension.
- R2: When load_i is high at a rising edge, the state becomes seed_i, whatever the value of adv_i.
- R3: When load_i and adv_i are both low, the state does not change.
- R4: Without the extension, advancing from the reset default returns to the default after exactly 2^n−1 steps. No state repeats inside that loop, and the lockup value (all zeros for XOR, all ones for XNOR) never appears. This is checked for n = 4, 8 and 10 in every structure and gate combination.
- R5: With the extension, the same loop is exactly 2^n steps long, with no repeated state. It therefore visits every n-bit value, for the same widths and combinations.
- R6: Without the extension, a loaded lockup value (all zeros for XOR, all ones for XNOR) stays unchanged while advancing.
- R7: One-to-many XOR step: the register shifts toward the MSB, the old MSB enters the LSB, and the old MSB is also XORed into every tapped stage. For n = 4 the tapped-stage mask is 4'b1001. Starting from 4'b0001 the states are 0010, 0100, 1000, 1001, 1011.
- R8: Many-to-one XOR step: the register shifts toward the MSB and the new LSB is the XOR of the tapped bits. For n = 4 these are bits 3 and 2. Starting from 4'b0001 the states are 0010, 0100, 1001, 0011, 0110.
- R9: For any structure and extension setting, the XNOR variant started from the bitwise complement of an XOR variant's state produces the bitwise complement of each following XOR state. Example: one-to-many XNOR with n = 4 from 0000 gives 1000, 0001, 1010, 0101, 0010.
- R10: With the extension and XOR, the state with only the MSB set moves to all zeros. All zeros then moves to 4'b1001 for one-to-many and to 4'b0001 for many-to-one (n = 4). With XNOR the roles are complemented: 0111 goes to 1111, and 1111 goes to 0110 for one-to-many or to 1110 for many-to-one.
- R11: The width parameter selects its table entry. For n = 10 the many-to-one taps are bits 9 and 6, so seed 10'h001 reaches 10'h081 after 7 steps. In one-to-many form, 10'h200 steps to 10'h081. A width outside 2..32 stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous active-high reset to the default state |
| adv_i | input | 1 | Advance the register by one state |
| load_i | input | 1 | Load seed_i; wins over adv_i |
| seed_i | input | WIDTH | Seed value for load |
| state_o | output | WIDTH | Current register state |

## Verification
The state register drives state_o directly, so any corrupted bit is visible at the ports in the cycle after the edge that wrote it. A wrong tap, a misplaced correction term or a wrong gate polarity changes the next value at once. The directed sequences and boundary transitions expose such faults within one to seven steps. Faults that only shorten or split the loop show up in the period sweep within at most 2^n steps, as an early return to the start value, a repeated state or a visit to the lockup value.

// File: rtl/lfsr_gen_pkg.sv
package lfsr_gen_pkg;

   typedef enum logic {
      LFSR_ONE_TO_MANY = 1'b0,
      LFSR_MANY_TO_ONE = 1'b1
   } lfsr_struct_e;

   typedef enum logic {
      LFSR_GATE_XOR  = 1'b0,
      LFSR_GATE_XNOR = 1'b1
   } lfsr_gate_e;

   localparam int unsigned LFSR_MIN_W = 2;
   localparam int unsigned LFSR_MAX_W = 32;

   // one set bit for a 1-based tap position
   function automatic logic [31:0] tap_bit(int unsigned pos);
      return 32'd1 << (pos - 1);
   endfunction

   function automatic logic [31:0] width_mask(int unsigned w);
      return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
   endfunction

   // many-to-one tap mask: bit i set means state bit i feeds the parity
   function automatic logic [31:0] fib_taps(int unsigned w);
      case (w)
         2:  return tap_bit(2)  | tap_bit(1);
         3:  return tap_bit(3)  | tap_bit(2);
         4:  return tap_bit(4)  | tap_bit(3);
         5:  return tap_bit(5)  | tap_bit(3);
         6:  return tap_bit(6)  | tap_bit(5);
         7:  return tap_bit(7)  | tap_bit(6);
         8:  return tap_bit(8)  | tap_bit(6) | tap_bit(5) | tap_bit(4);
         9:  return tap_bit(9)  | tap_bit(5);
         10: return tap_bit(10) | tap_bit(7);
         11: return tap_bit(11) | tap_bit(9);
         12: return tap_bit(12) | tap_bit(6) | tap_bit(4) | tap_bit(1);
         13: return tap_bit(13) | tap_bit(4) | tap_bit(3) | tap_bit(1);
         14: return tap_bit(14) | tap_bit(5) | tap_bit(3) | tap_bit(1);
         15: return tap_bit(15) | tap_bit(14);
         16: return tap_bit(16) | tap_bit(15) | tap_bit(13) | tap_bit(4);
         17: return tap_bit(17) | tap_bit(14);
         18: return tap_bit(18) | tap_bit(11);
         19: return tap_bit(19) | tap_bit(6) | tap_bit(2) | tap_bit(1);
         20: return tap_bit(20) | tap_bit(17);
         21: return tap_bit(21) | tap_bit(19);
         22: return tap_bit(22) | tap_bit(21);
         23: return tap_bit(23) | tap_bit(18);
         24: return tap_bit(24) | tap_bit(23) | tap_bit(22) | tap_bit(17);
         25: return tap_bit(25) | tap_bit(22);
         26: return tap_bit(26) | tap_bit(6) | tap_bit(2) | tap_bit(1);
         27: return tap_bit(27) | tap_bit(5) | tap_bit(2) | tap_bit(1);
         28: return tap_bit(28) | tap_bit(25);
         29: return tap_bit(29) | tap_bit(27);
         30: return tap_bit(30) | tap_bit(6) | tap_bit(4) | tap_bit(1);
         31: return tap_bit(31) | tap_bit(28);
         32: return tap_bit(32) | tap_bit(22) | tap_bit(2) | tap_bit(1);
         default: return 32'h0;
      endcase
   endfunction

   // one-to-many mask: bit i set means stage i receives the MSB (bit 0 always)
   function automatic logic [31:0] galois_taps(int unsigned w);
      return ((fib_taps(w) << 1) & width_mask(w)) | 32'd1;
   endfunction

   function automatic logic [31:0] reset_value(lfsr_gate_e gate);
      return (gate == LFSR_GATE_XNOR) ? 32'h0 : 32'hFFFF_FFFF;
   endfunction

endpackage

// File: rtl/lfsr_run_detect.sv
// Flags the lower bits sitting at the lockup pattern (correction for full cycle).
module lfsr_run_detect
   import lfsr_gen_pkg::*;
#(
   parameter int unsigned BITS = 3,
   parameter lfsr_gate_e  GATE = LFSR_GATE_XOR
) (
   input  logic [BITS-1:0] low_i,
   output logic            hit_o
);

   generate
      if (GATE == LFSR_GATE_XNOR) begin : g_ones
         assign hit_o = &low_i;
      end else begin : g_zeros
         assign hit_o = ~|low_i;
      end
   endgenerate

endmodule

// File: rtl/lfsr_step_galois.sv
// One-to-many next state: MSB (with correction) fans out to tapped stages.
module lfsr_step_galois
   import lfsr_gen_pkg::*;
#(
   parameter int unsigned      W        = 4,
   parameter lfsr_gate_e       GATE     = LFSR_GATE_XOR,
   parameter logic [W-1:0]     TAP_MASK = '1
) (
   input  logic [W-1:0] state_i,
   input  logic         fix_i,
   output logic [W-1:0] next_o
);

   logic fb;
   assign fb        = state_i[W-1] ^ fix_i;
   assign next_o[0] = fb;

   generate
      for (genvar i = 1; i < W; i++) begin : g_stage
         if (!TAP_MASK[i]) begin : g_pass
            assign next_o[i] = state_i[i-1];
         end else if (GATE == LFSR_GATE_XNOR) begin : g_xnor
            assign next_o[i] = ~(state_i[i-1] ^ fb);
         end else begin : g_xor
            assign next_o[i] = state_i[i-1] ^ fb;
         end
      end
   endgenerate

endmodule

// File: rtl/lfsr_step_fibonacci.sv
// Many-to-one next state: parity of tapped bits (with correction) enters the LSB.
module lfsr_step_fibonacci
   import lfsr_gen_pkg::*;
#(
   parameter int unsigned      W        = 4,
   parameter lfsr_gate_e       GATE     = LFSR_GATE_XOR,
   parameter logic [W-1:0]     TAP_MASK = '1
) (
   input  logic [W-1:0] state_i,
   input  logic         fix_i,
   output logic [W-1:0] next_o
);

   logic parity;
   logic fb;

   assign parity = ^(state_i & TAP_MASK);

   generate
      if (GATE == LFSR_GATE_XNOR) begin : g_xnor
         assign fb = ~parity ^ fix_i;
      end else begin : g_xor
         assign fb = parity ^ fix_i;
      end
   endgenerate

   assign next_o = {state_i[W-2:0], fb};

endmodule

// File: rtl/lfsr_gen.sv
module lfsr_gen
   import lfsr_gen_pkg::*;
#(
   parameter int unsigned  WIDTH      = 16,
   parameter lfsr_struct_e STRUCT     = LFSR_ONE_TO_MANY,
   parameter lfsr_gate_e   GATE       = LFSR_GATE_XOR,
   parameter bit           FULL_CYCLE = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             adv_i,
   input  logic             load_i,
   input  logic [WIDTH-1:0] seed_i,
   output logic [WIDTH-1:0] state_o
);

   localparam logic [31:0]      FIB_ALL  = fib_taps(WIDTH);
   localparam logic [31:0]      GAL_ALL  = galois_taps(WIDTH);
   localparam logic [31:0]      RST_ALL  = reset_value(GATE);
   localparam logic [WIDTH-1:0] FIB_MASK = FIB_ALL[WIDTH-1:0];
   localparam logic [WIDTH-1:0] GAL_MASK = GAL_ALL[WIDTH-1:0];
   localparam logic [WIDTH-1:0] RST_VAL  = RST_ALL[WIDTH-1:0];
   localparam int unsigned      LOW_W    = WIDTH - 1;

   // elaboration-time parameter checks
   generate
      if (WIDTH < LFSR_MIN_W || WIDTH > LFSR_MAX_W) begin : g_bad_width
         $error("lfsr_gen: WIDTH %0d outside supported range", WIDTH);
      end
      if (FIB_ALL[WIDTH-1] != 1'b1) begin : g_bad_table
         $error("lfsr_gen: tap entry for WIDTH %0d lacks its MSB tap", WIDTH);
      end
   endgenerate

   logic [WIDTH-1:0] state_q;
   logic [WIDTH-1:0] next_w;
   logic             fix_w;

   // full-cycle correction term
   generate
      if (FULL_CYCLE) begin : g_full
         lfsr_run_detect #(
            .BITS (LOW_W),
            .GATE (GATE)
         ) u_detect (
            .low_i (state_q[LOW_W-1:0]),
            .hit_o (fix_w)
         );
      end else begin : g_plain
         assign fix_w = 1'b0;
      end
   endgenerate

   // structure select
   generate
      if (STRUCT == LFSR_ONE_TO_MANY) begin : g_galois
         lfsr_step_galois #(
            .W        (WIDTH),
            .GATE     (GATE),
            .TAP_MASK (GAL_MASK)
         ) u_step (
            .state_i (state_q),
            .fix_i   (fix_w),
            .next_o  (next_w)
         );
      end else begin : g_fibonacci
         lfsr_step_fibonacci #(
            .W        (WIDTH),
            .GATE     (GATE),
            .TAP_MASK (FIB_MASK)
         ) u_step (
            .state_i (state_q),
            .fix_i   (fix_w),
            .next_o  (next_w)
         );
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= RST_VAL;
      end else if (load_i) begin
         state_q <= seed_i;
      end else if (adv_i) begin
         state_q <= next_w;
      end
   end

   assign state_o = state_q;

endmodule

// File: rtl/lfsr_gen_chk.sv
module lfsr_gen_chk
   import lfsr_gen_pkg::*;
#(
   parameter int unsigned WIDTH      = 16,
   parameter lfsr_gate_e  GATE       = LFSR_GATE_XOR,
   parameter bit          FULL_CYCLE = 1'b0
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             adv_i,
   input logic             load_i,
   input logic [WIDTH-1:0] seed_i,
   input logic [WIDTH-1:0] state_o
);

   localparam logic [WIDTH-1:0] LOCK = (GATE == LFSR_GATE_XNOR) ? '1 : '0;
   // the state just before the lockup value in the extended loop
   localparam logic [WIDTH-1:0] EDGE = LOCK ^ {1'b1, {(WIDTH-1){1'b0}}};

   p_seed_load_r2 : assert property (@(posedge clk_i) disable iff (rst_i)
      load_i |=> state_o == $past(seed_i));

   p_idle_hold_r3 : assert property (@(posedge clk_i) disable iff (rst_i)
      (!load_i && !adv_i) |=> $stable(state_o));

   p_lockup_avoid_r4 : assert property (@(posedge clk_i) disable iff (rst_i)
      (!FULL_CYCLE && !load_i && state_o != LOCK) |=> state_o != LOCK);

   p_step_changes_r5 : assert property (@(posedge clk_i) disable iff (rst_i)
      (adv_i && !load_i && (FULL_CYCLE || state_o != LOCK)) |=> state_o != $past(state_o));

   p_edge_to_lock_r10 : assert property (@(posedge clk_i) disable iff (rst_i)
      (FULL_CYCLE && adv_i && !load_i && state_o == EDGE) |=> state_o == LOCK);

endmodule

bind lfsr_gen lfsr_gen_chk #(
   .WIDTH      (WIDTH),
   .GATE       (GATE),
   .FULL_CYCLE (FULL_CYCLE)
) u_lfsr_gen_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .adv_i   (adv_i),
   .load_i  (load_i),
   .seed_i  (seed_i),
   .state_o (state_o)
);

// File: tb/test_lfsr_gen.sv
`timescale 1ns/1ps
module test_lfsr_gen;
   import lfsr_gen_pkg::*;

   localparam int NCFG = 24;

   // config index k: width = {4,8,10}[k/8]; bit2 structure; bit1 gate; bit0 extension
   function automatic int cfg_w(int k);
      case (k / 8)
         0: return 4;
         1: return 8;
         default: return 10;
      endcase
   endfunction
   function automatic int cfg_s(int k); return (k % 8) / 4; endfunction
   function automatic int cfg_g(int k); return (k % 4) / 2; endfunction
   function automatic int cfg_x(int k); return k % 2;       endfunction
   function automatic logic [31:0] wmask(int w);
      return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
   endfunction

   logic        clk  = 1'b0;
   logic        rst  = 1'b1;
   logic        adv  = 1'b0;
   logic        load = 1'b0;
   logic [31:0] seed = 32'h0;
   logic [31:0] st [NCFG];

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   generate
      for (genvar g = 0; g < NCFG; g++) begin : g_cfg
         localparam int W = cfg_w(g);
         logic [W-1:0] q;
         lfsr_gen #(
            .WIDTH      (W),
            .STRUCT     (lfsr_struct_e'(cfg_s(g))),
            .GATE       (lfsr_gate_e'(cfg_g(g))),
            .FULL_CYCLE (cfg_x(g) == 1)
         ) i_lfsr_gen (
            .clk_i   (clk),
            .rst_i   (rst),
            .adv_i   (adv),
            .load_i  (load),
            .seed_i  (seed[W-1:0]),
            .state_o (q)
         );
         assign st[g] = 32'(q);
      end
   endgenerate

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // drive at a falling edge, sample at the next falling edge
   task automatic tick(logic a, logic l, logic [31:0] s);
      adv = a; load = l; seed = s;
      @(negedge clk);
      adv = 1'b0; load = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      tick(1'b0, 1'b0, 32'h0);
      tick(1'b0, 1'b0, 32'h0);
      rst = 1'b0;
   endtask

   task automatic t_reset_default();
      do_reset();
      for (int k = 0; k < NCFG; k++)
         check("R1", $sformatf("reset cfg %0d", k), st[k],
               cfg_g(k) == 1 ? 32'h0 : wmask(cfg_w(k)));
   endtask

   task automatic t_load_priority();
      tick(1'b1, 1'b1, 32'h5);
      for (int k = 0; k < NCFG; k++)
         check("R2", $sformatf("load+adv cfg %0d", k), st[k], 32'h5);
      tick(1'b0, 1'b1, 32'hA);
      for (int k = 0; k < NCFG; k += 5)
         check("R2", $sformatf("load cfg %0d", k), st[k], 32'hA);
   endtask

   task automatic t_hold();
      logic [31:0] snap [NCFG];
      tick(1'b1, 1'b0, 32'h0);
      for (int k = 0; k < NCFG; k++) snap[k] = st[k];
      for (int c = 0; c < 3; c++) tick(1'b0, 1'b0, 32'h0);
      for (int k = 0; k < NCFG; k++)
         check("R3", $sformatf("idle cfg %0d", k), st[k], snap[k]);
   endtask

   task automatic t_seq(string req, int k, logic [31:0] s0, int n, logic [31:0] e [5]);
      tick(1'b0, 1'b1, s0);
      for (int i = 0; i < n; i++) begin
         tick(1'b1, 1'b0, 32'h0);
         check(req, $sformatf("cfg %0d step %0d", k, i + 1), st[k], e[i]);
      end
   endtask

   task automatic t_lockup();
      tick(1'b0, 1'b1, 32'h0);
      for (int c = 0; c < 4; c++) tick(1'b1, 1'b0, 32'h0);
      for (int k = 0; k < NCFG; k++)
         if (cfg_g(k) == 0 && cfg_x(k) == 0)
            check("R6", $sformatf("xor lockup cfg %0d", k), st[k], 32'h0);
      tick(1'b0, 1'b1, 32'h3FF);
      for (int c = 0; c < 4; c++) tick(1'b1, 1'b0, 32'h0);
      for (int k = 0; k < NCFG; k++)
         if (cfg_g(k) == 1 && cfg_x(k) == 0)
            check("R6", $sformatf("xnor lockup cfg %0d", k), st[k], wmask(cfg_w(k)));
   endtask

   task automatic t_complement();
      do_reset();
      for (int c = 0; c < 9; c++) begin
         tick(1'b1, 1'b0, 32'h0);
         for (int k = 0; k < NCFG; k++)
            if (cfg_g(k) == 0 && (c == 3 || c == 8))
               check("R9", $sformatf("complement cfg %0d/%0d step %0d", k, k + 2, c + 1),
                     st[k + 2], ~st[k] & wmask(cfg_w(k)));
      end
   endtask

   task automatic t_width10();
      tick(1'b0, 1'b1, 32'h001);
      for (int c = 0; c < 7; c++) tick(1'b1, 1'b0, 32'h0);
      check("R11", "10-bit many-to-one 7 steps", st[20], 32'h081);
      tick(1'b0, 1'b1, 32'h200);
      tick(1'b1, 1'b0, 32'h0);
      check("R11", "10-bit one-to-many from MSB", st[16], 32'h081);
   endtask

   task automatic t_period();
      bit          seen [NCFG][1024];
      bit          done [NCFG];
      bit          dup  [NCFG];
      bit          lockh[NCFG];
      int          per  [NCFG];
      logic [31:0] start[NCFG];
      do_reset();
      for (int k = 0; k < NCFG; k++) begin
         for (int v = 0; v < 1024; v++) seen[k][v] = 1'b0;
         done[k] = 1'b0; dup[k] = 1'b0; lockh[k] = 1'b0; per[k] = 0;
         start[k] = st[k];
         seen[k][st[k][9:0]] = 1'b1;
      end
      for (int t = 1; t <= 1026; t++) begin
         tick(1'b1, 1'b0, 32'h0);
         for (int k = 0; k < NCFG; k++) begin
            if (!done[k]) begin
               if (cfg_x(k) == 0 && st[k] == (cfg_g(k) == 1 ? wmask(cfg_w(k)) : 32'h0))
                  lockh[k] = 1'b1;
               if (st[k] == start[k]) begin
                  done[k] = 1'b1;
                  per[k]  = t;
               end else begin
                  if (seen[k][st[k][9:0]]) dup[k] = 1'b1;
                  seen[k][st[k][9:0]] = 1'b1;
               end
            end
         end
      end
      for (int k = 0; k < NCFG; k++) begin
         if (cfg_x(k) == 1) begin
            check("R5", $sformatf("period cfg %0d", k), per[k], 32'd1 << cfg_w(k));
            check("R5", $sformatf("repeat cfg %0d", k), {31'd0, dup[k]}, 32'd0);
         end else begin
            check("R4", $sformatf("period cfg %0d", k), per[k], (32'd1 << cfg_w(k)) - 1);
            check("R4", $sformatf("repeat/lockup cfg %0d", k),
                  {30'd0, dup[k], lockh[k]}, 32'd0);
         end
      end
   endtask

   initial begin
      logic [31:0] e [5];
      @(negedge clk);
      t_reset_default();
      t_load_priority();
      t_hold();
      e = '{32'h2, 32'h4, 32'h8, 32'h9, 32'hB};
      t_seq("R7", 0, 32'h1, 5, e);
      e = '{32'h2, 32'h4, 32'h9, 32'h3, 32'h6};
      t_seq("R8", 4, 32'h1, 5, e);
      e = '{32'h8, 32'h1, 32'hA, 32'h5, 32'h2};
      t_seq("R9", 2, 32'h0, 5, e);
      e = '{32'h0, 32'h9, 32'hB, 32'h0, 32'h0};
      t_seq("R10", 1, 32'h8, 3, e);
      e = '{32'h0, 32'h1, 32'h2, 32'h0, 32'h0};
      t_seq("R10", 5, 32'h8, 3, e);
      e = '{32'hF, 32'h6, 32'h4, 32'h0, 32'h0};
      t_seq("R10", 3, 32'h7, 3, e);
      e = '{32'hF, 32'hE, 32'hD, 32'h0, 32'h0};
      t_seq("R10", 7, 32'h7, 3, e);
      t_lockup();
      t_complement();
      t_width10();
      t_period();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule